// File: doc/BRIEF.md
# Event-Driven Counter Action Controller

This block is an up/down counter with a programmable wrap limit. Two event lines, A and B, steer it. Each line has an enable bit, a polarity-invert bit and a 3-bit action selector. The block first conditions each line: it masks the line with its enable and XORs it with its invert bit. It then detects edges on the conditioned level. The two selectors decode the edges and levels into counter operations. These operations are start, reload, halt, counting on events, counting while a level is active, manual increment and decrement, direction following, timestamp and pulse-width/period capture, and a latched fault that cannot be recovered.

An event is a rising edge of a conditioned line. The block registers the previous conditioned level once per clock. The counter, direction, running flag, capture registers, fault flag and wrap strobe are all registered. Each of them updates on the clock edge that samples the request.

Top module: `evt_counter_ctl`

## Requirements
- R1: While `rst` is high, every output settles to zero on the next clock edge (count, direction, running, both captures, fault, wrap strobe).
- R2: While a line's enable is 0, that line has no effect at all. Its conditioned level is 0, so it produces no edges and no gating.
- R3: A line's conditioned level is `en & (ev ^ inv)`. An event is a 0-to-1 change of that level between two consecutive clock samples.
- R4: While running and not gated, the counter moves one step per clock. Counting up, a value at or above `top` goes to 0. Counting down, 0 goes to `top`. `wrap_o` is high for exactly the cycle in which the wrapped value is shown.
- R5: Selector code 1 on either line (reload) loads 0 when counting up and `top` when counting down, and sets running. Code 3 on line A (start) sets running without changing the count. The first step comes one cycle later.
- R6: Code 3 on line B (halt) clears running. The count then holds.
- R7: Line A code 2 makes the counter step once per event. Line A code 5 makes it step on every clock while A's level is high. Both require running.
- R8: Line A code 4 adds one per event and line B code 4 subtracts one per event. This happens whether or not the counter is running, and it uses the same wrap rules. That cycle's normal step is skipped. If both events fall in the same cycle, they cancel and the count holds.
- R9: Line B code 2 makes the direction equal to B's conditioned level (1 = down). The new direction applies to the step in the same cycle.
- R10: Line A code 6 copies the count into `cap0_o` on each event. Line B code 6 copies the count into `cap1_o` on a rising edge and reloads as in R5, and copies the count into `cap0_o` on a falling edge. Codes 0 and line B code 5 do nothing.
- R11: Code 7 on either line sets `fault_o` and clears running. From then until reset, the count is frozen, start and reload are refused, and `fault_o` stays 1.
- R12: When requests from the two lines collide, the precedence is fault, then halt, then reload/start, then count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_a | input | 1 | Enable of line A |
| inv_a | input | 1 | Invert of line A |
| sel_a | input | 3 | Action selector of line A |
| ev_a | input | 1 | Event line A |
| en_b | input | 1 | Enable of line B |
| inv_b | input | 1 | Invert of line B |
| sel_b | input | 3 | Action selector of line B |
| ev_b | input | 1 | Event line B |
| top | input | W | Wrap limit |
| count_o | output | W | Counter value |
| down_o | output | 1 | Direction, 1 = counting down |
| running_o | output | 1 | Counter running |
| cap0_o | output | W | Capture register 0 |
| cap1_o | output | W | Capture register 1 |
| fault_o | output | 1 | Sticky fault flag |
| wrap_o | output | 1 | Wrap strobe |

## Verification
A reload on one line and a count change on the other can fall in the same cycle. So can a halt and a reload, or a fault and a start. Directed sequences line up these edges on the same clock sample: line A pulses a reload or fault while line B pulses a halt or decrement, and the reverse. The outputs are judged against a bench model of the R12 precedence. Long random runs with freshly drawn selectors then produce many more such collisions. These include a period-capture rising edge, which both captures and reloads, landing on a wrap.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [2:0] {
        A_OFF    = 3'd0,
        A_RELOAD = 3'd1,
        A_EVCNT  = 3'd2,
        A_START  = 3'd3,
        A_INC    = 3'd4,
        A_LVLCNT = 3'd5,
        A_STAMP  = 3'd6,
        A_FAULT  = 3'd7
    } sel_a_e;

    typedef enum logic [2:0] {
        B_OFF    = 3'd0,
        B_RELOAD = 3'd1,
        B_DIR    = 3'd2,
        B_HALT   = 3'd3,
        B_DEC    = 3'd4,
        B_NONE   = 3'd5,
        B_PWP    = 3'd6,
        B_FAULT  = 3'd7
    } sel_b_e;

    typedef struct packed {
        logic lvl;
        logic prev;
    } line_t;

    typedef struct packed {
        logic fault;
        logic halt;
        logic reload;
        logic start;
        logic inc;
        logic dec;
        logic tick;
        logic dir_ovr;
        logic dir_val;
        logic cap0_take;
        logic cap1_take;
    } req_t;

    function automatic logic rose(input line_t s);
        return s.lvl & ~s.prev;
    endfunction

    function automatic logic fell(input line_t s);
        return ~s.lvl & s.prev;
    endfunction

endpackage

// File: rtl/evc_line_cond.sv
module evc_line_cond
    import evc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  inv,
    input  logic  ev,
    output line_t sig
);
    logic lvl;
    logic prev_q;

    assign lvl = en & (ev ^ inv);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign sig.lvl  = lvl;
    assign sig.prev = prev_q;
endmodule

// File: rtl/evc_decode.sv
module evc_decode
    import evc_pkg::*;
(
    input  logic       en_a,
    input  logic [2:0] sel_a,
    input  line_t      sa,
    input  logic       en_b,
    input  logic [2:0] sel_b,
    input  line_t      sb,
    output req_t       req
);
    sel_a_e ma;
    sel_b_e mb;
    logic   ra, rb, fb, gated;

    always_comb begin
        ma    = sel_a_e'(sel_a);
        mb    = sel_b_e'(sel_b);
        ra    = rose(sa);
        rb    = rose(sb);
        fb    = fell(sb);
        gated = en_a & (ma == A_EVCNT || ma == A_LVLCNT);

        req.fault     = (ma == A_FAULT & ra) | (mb == B_FAULT & rb);
        req.halt      = (mb == B_HALT & rb);
        req.reload    = (ma == A_RELOAD & ra) | (mb == B_RELOAD & rb) | (mb == B_PWP & rb);
        req.start     = (ma == A_START & ra);
        req.inc       = (ma == A_INC & ra);
        req.dec       = (mb == B_DEC & rb);
        req.tick      = ~gated | (ma == A_EVCNT & ra) | (ma == A_LVLCNT & sa.lvl);
        req.dir_ovr   = en_b & (mb == B_DIR);
        req.dir_val   = sb.lvl;
        req.cap0_take = (ma == A_STAMP & ra) | (mb == B_PWP & fb);
        req.cap1_take = (mb == B_PWP & rb);
    end
endmodule

// File: rtl/evc_counter_core.sv
module evc_counter_core
    import evc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] top,
    input  req_t         req,
    output logic [W-1:0] count,
    output logic         down,
    output logic         running,
    output logic         fault,
    output logic         wrap
);
    logic [W-1:0] cnt_q, cnt_n;
    logic         dir_q, dir_eff, run_q, run_n, flt_q, flt_n, wrap_q, wrap_n;

    function automatic logic [W:0] step(input logic [W-1:0] c, input logic dn,
                                        input logic [W-1:0] lim);
        if (dn) return (c == '0) ? {1'b1, lim} : {1'b0, c - 1'b1};
        else    return (c >= lim) ? {1'b1, {W{1'b0}}} : {1'b0, c + 1'b1};
    endfunction

    always_comb begin
        dir_eff = req.dir_ovr ? req.dir_val : dir_q;
        cnt_n   = cnt_q;
        run_n   = run_q;
        flt_n   = flt_q;
        wrap_n  = 1'b0;
        if (flt_q || req.fault) begin
            flt_n = 1'b1;
            run_n = 1'b0;
        end else if (req.halt) begin
            run_n = 1'b0;
        end else if (req.reload) begin
            cnt_n = dir_eff ? top : '0;
            run_n = 1'b1;
        end else begin
            if (req.start) run_n = 1'b1;
            if (req.inc || req.dec) begin
                if (req.inc ^ req.dec) {wrap_n, cnt_n} = step(cnt_q, req.dec, top);
            end else if (run_q && req.tick) begin
                {wrap_n, cnt_n} = step(cnt_q, dir_eff, top);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            run_q  <= 1'b0;
            flt_q  <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            dir_q  <= dir_eff;
            run_q  <= run_n;
            flt_q  <= flt_n;
            wrap_q <= wrap_n;
        end
    end

    assign count   = cnt_q;
    assign down    = dir_q;
    assign running = run_q;
    assign fault   = flt_q;
    assign wrap    = wrap_q;
endmodule

// File: rtl/evc_capture.sv
module evc_capture
    import evc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] count,
    input  req_t         req,
    output logic [W-1:0] cap0,
    output logic [W-1:0] cap1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap0 <= '0;
            cap1 <= '0;
        end else begin
            if (req.cap0_take) cap0 <= count;
            if (req.cap1_take) cap1 <= count;
        end
    end
endmodule

// File: rtl/evt_counter_ctl.sv
module evt_counter_ctl
    import evc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_a,
    input  logic         inv_a,
    input  logic [2:0]   sel_a,
    input  logic         ev_a,
    input  logic         en_b,
    input  logic         inv_b,
    input  logic [2:0]   sel_b,
    input  logic         ev_b,
    input  logic [W-1:0] top,
    output logic [W-1:0] count_o,
    output logic         down_o,
    output logic         running_o,
    output logic [W-1:0] cap0_o,
    output logic [W-1:0] cap1_o,
    output logic         fault_o,
    output logic         wrap_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] en_v, inv_v, ev_v;
    line_t             sig [NLINES];
    req_t              req;

    assign en_v  = {en_b, en_a};
    assign inv_v = {inv_b, inv_a};
    assign ev_v  = {ev_b, ev_a};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        evc_line_cond u_cond (
            .clk (clk),
            .rst (rst),
            .en  (en_v[i]),
            .inv (inv_v[i]),
            .ev  (ev_v[i]),
            .sig (sig[i])
        );
    end

    evc_decode u_dec (
        .en_a  (en_a),
        .sel_a (sel_a),
        .sa    (sig[0]),
        .en_b  (en_b),
        .sel_b (sel_b),
        .sb    (sig[1]),
        .req   (req)
    );

    evc_counter_core #(.W(W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .top     (top),
        .req     (req),
        .count   (count_o),
        .down    (down_o),
        .running (running_o),
        .fault   (fault_o),
        .wrap    (wrap_o)
    );

    evc_capture #(.W(W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .count (count_o),
        .req   (req),
        .cap0  (cap0_o),
        .cap1  (cap1_o)
    );
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en_a,
    input logic         en_b,
    input logic [W-1:0] top,
    input logic [W-1:0] count_o,
    input logic         running_o,
    input logic         fault_o,
    input logic         wrap_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !running_o && !fault_o && !wrap_o)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!en_a && !en_b && !running_o && !fault_o) |=> ($stable(count_o) && !running_o)); // R2

    AST_WRAP_VALUE: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && $stable(top)) |-> (count_o == '0 || count_o == top)); // R4

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> fault_o); // R11

    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !running_o); // R11

    AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> $stable(count_o)); // R11
endmodule

bind evt_counter_ctl evc_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_a      (en_a),
    .en_b      (en_b),
    .top       (top),
    .count_o   (count_o),
    .running_o (running_o),
    .fault_o   (fault_o),
    .wrap_o    (wrap_o)
);

// File: tb/evt_counter_ctl_tb_top.sv
`timescale 1ns/1ps
module evt_counter_ctl_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_a = 0, inv_a = 0, ev_a = 0, en_b = 0, inv_b = 0, ev_b = 0;
    logic [2:0] sel_a = 0, sel_b = 0;
    logic [W-1:0] top = 8'd5;
    logic [W-1:0] count_o, cap0_o, cap1_o;
    logic down_o, running_o, fault_o, wrap_o;

    always #2.5 clk = ~clk;

    evt_counter_ctl #(.W(W)) dut_i (
        .clk(clk), .rst(rst),
        .en_a(en_a), .inv_a(inv_a), .sel_a(sel_a), .ev_a(ev_a),
        .en_b(en_b), .inv_b(inv_b), .sel_b(sel_b), .ev_b(ev_b),
        .top(top), .count_o(count_o), .down_o(down_o), .running_o(running_o),
        .cap0_o(cap0_o), .cap1_o(cap1_o), .fault_o(fault_o), .wrap_o(wrap_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] m_cnt, m_c0, m_c1;
    logic m_dn, m_run, m_flt, m_wrap, m_pa, m_pb;

    function automatic logic [W:0] m_step(input logic [W-1:0] c, input logic dn, input logic [W-1:0] lim);
        if (dn) return (c == 0) ? {1'b1, lim} : {1'b0, c - 8'd1};
        return (c >= lim) ? {1'b1, 8'd0} : {1'b0, c + 8'd1};
    endfunction

    // Reference model, updated once per clock edge from the requirements
    task automatic model_clk();
        logic la, lb, ra, rb, fb, d, gated, tick, flt, halt, rel, st, inc, dec;
        if (rst) begin
            m_cnt = 0; m_c0 = 0; m_c1 = 0; m_dn = 0; m_run = 0;
            m_flt = 0; m_wrap = 0; m_pa = 0; m_pb = 0;
            return;
        end
        la = en_a & (ev_a ^ inv_a);          // R3
        lb = en_b & (ev_b ^ inv_b);
        ra = la & !m_pa; rb = lb & !m_pb; fb = !lb & m_pb;
        d = (en_b && sel_b == 3'd2) ? lb : m_dn;   // R9
        gated = en_a && (sel_a == 3'd2 || sel_a == 3'd5);
        tick = !gated || (sel_a == 3'd2 && ra) || (sel_a == 3'd5 && la); // R7
        flt  = (sel_a == 3'd7 && ra) || (sel_b == 3'd7 && rb);
        halt = sel_b == 3'd3 && rb;
        rel  = (sel_a == 3'd1 && ra) || ((sel_b == 3'd1 || sel_b == 3'd6) && rb);
        st   = sel_a == 3'd3 && ra;
        inc  = sel_a == 3'd4 && ra;
        dec  = sel_b == 3'd4 && rb;
        if ((sel_a == 3'd6 && ra) || (sel_b == 3'd6 && fb)) m_c0 = m_cnt; // R10
        if (sel_b == 3'd6 && rb) m_c1 = m_cnt;
        m_wrap = 0;
        if (m_flt || flt) begin m_flt = 1; m_run = 0; end        // R11 R12
        else if (halt) m_run = 0;                                  // R6
        else if (rel) begin m_cnt = d ? top : 0; m_run = 1; end    // R5
        else begin
            if (inc || dec) begin                                  // R8
                if (inc != dec) {m_wrap, m_cnt} = m_step(m_cnt, dec, top);
            end else if (m_run && tick) {m_wrap, m_cnt} = m_step(m_cnt, d, top); // R4
            if (st) m_run = 1;
        end
        m_dn = d; m_pa = la; m_pb = lb;
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (count_o !== m_cnt || down_o !== m_dn || running_o !== m_run || cap0_o !== m_c0 ||
            cap1_o !== m_c1 || fault_o !== m_flt || wrap_o !== m_wrap) begin
            n_bad++;
            $display("FAIL %s: got cnt=%0d dn=%0b run=%0b c0=%0d c1=%0d flt=%0b wrap=%0b exp cnt=%0d dn=%0b run=%0b c0=%0d c1=%0d flt=%0b wrap=%0b",
                     tag, count_o, down_o, running_o, cap0_o, cap1_o, fault_o, wrap_o,
                     m_cnt, m_dn, m_run, m_c0, m_c1, m_flt, m_wrap);
        end
    endtask

    task automatic cyc(input string tag);
        model_clk();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic pulse_a(input string tag);
        ev_a = ~inv_a; cyc(tag); ev_a = inv_a; cyc(tag);
    endtask

    task automatic pulse_b(input string tag);
        ev_b = ~inv_b; cyc(tag); ev_b = inv_b; cyc(tag);
    endtask

    task automatic do_reset();
        rst = 1; en_a = 0; en_b = 0; inv_a = 0; inv_b = 0; ev_a = 0; ev_b = 0;
        sel_a = 0; sel_b = 0;
        cyc("R1"); cyc("R1");
        rst = 0;
    endtask

    task automatic expect_val(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d exp %0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        expect_val("R1", count_o, 0);
        expect_val("R1", {7'd0, running_o}, 0);

        // R2: disabled line with reload / fault selectors does nothing
        sel_a = 3'd1; sel_b = 3'd7;
        pulse_a("R2"); pulse_b("R2"); run(3, "R2");
        expect_val("R2", {7'd0, running_o}, 0);

        // R5 R4: reload then free count up through wrap
        en_a = 1; pulse_a("R5"); run(12, "R4");
        // R9 R4: direction follows line B, down wrap
        en_b = 1; sel_b = 3'd2; ev_b = 1; run(10, "R9"); ev_b = 0; run(3, "R9");
        // R6: halt
        sel_b = 3'd3; pulse_b("R6"); run(4, "R6");
        expect_val("R6", {7'd0, running_o}, 0);
        // R5: start keeps count
        sel_a = 3'd3; pulse_a("R5"); run(3, "R5");
        // R3: inverted line A
        inv_a = 1; ev_a = 1; cyc("R3"); sel_a = 3'd1; pulse_a("R3"); run(3, "R3");
        inv_a = 0; ev_a = 0; cyc("R3");
        // R7: event counting and level counting
        sel_a = 3'd2; sel_b = 3'd0; run(3, "R7"); pulse_a("R7"); pulse_a("R7");
        sel_a = 3'd5; ev_a = 1; run(4, "R7"); ev_a = 0; run(3, "R7");
        // R8: inc/dec while halted, and cancel
        sel_b = 3'd3; pulse_b("R8"); sel_a = 3'd4; sel_b = 3'd4;
        pulse_a("R8"); pulse_a("R8"); pulse_b("R8");
        ev_a = 1; ev_b = 1; cyc("R8"); ev_a = 0; ev_b = 0; cyc("R8");
        // R10: timestamp and period / pulse width
        sel_a = 3'd1; pulse_a("R10"); sel_a = 3'd6; run(2, "R10"); pulse_a("R10");
        expect_val("R10", cap0_o, m_c0);
        sel_a = 3'd0; sel_b = 3'd6;
        ev_b = 1; cyc("R10"); run(3, "R10"); ev_b = 0; run(4, "R10"); ev_b = 1; run(2, "R10"); ev_b = 0; cyc("R10");
        sel_b = 3'd5; pulse_b("R10");
        // R12: halt vs reload on the same sample
        sel_a = 3'd1; sel_b = 3'd3; ev_a = 1; ev_b = 1; cyc("R12"); ev_a = 0; ev_b = 0; run(2, "R12");
        expect_val("R12", {7'd0, running_o}, 0);
        // R12: reload vs decrement
        sel_b = 3'd4; ev_a = 1; ev_b = 1; cyc("R12"); ev_a = 0; ev_b = 0; run(2, "R12");
        // R11 R12: fault vs start, then refused start/reload
        sel_a = 3'd3; sel_b = 3'd7; ev_a = 1; ev_b = 1; cyc("R11"); ev_a = 0; ev_b = 0; cyc("R11");
        expect_val("R11", {7'd0, fault_o}, 1);
        sel_b = 3'd1; pulse_a("R11"); pulse_b("R11"); run(3, "R11");
        expect_val("R11", {7'd0, running_o}, 0);
        do_reset();

        // R12: random selectors and events against the model
        for (int k = 0; k < 6000; k++) begin
            if (k % 48 == 0) begin
                en_a = $urandom_range(0, 3) != 0; en_b = $urandom_range(0, 3) != 0;
                inv_a = $urandom_range(0, 1); inv_b = $urandom_range(0, 1);
                sel_a = $urandom_range(0, 6); sel_b = $urandom_range(0, 6);
                if ($urandom_range(0, 9) == 0) sel_b = 3'd7;
                top = $urandom_range(2, 20);
            end
            ev_a = $urandom_range(0, 2) == 0;
            ev_b = $urandom_range(0, 3) == 0;
            if (k % 600 == 599) do_reset();
            else cyc("R12");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule